// File: doc/BRIEF.md
# Enable and Strap Mode Controller

This block controls whether a converter core is powered or held in a low-power state. An external enable pin drives the decision. A second pin has two roles. At the moment enable rises, it is captured once as a configuration strap that selects high-performance operation. For as long as enable then stays high, the same pin acts as a live switch for de-emphasis.

The block runs on a slow, free-running control clock. It also checks that the master clock is still running. A flag in the master clock domain toggles on every master edge, and the control clock samples it. If the flag stops changing for a parameterised number of control cycles, power is withheld. Power returns as soon as the master clock moves again, provided enable is still high.

The de-emphasis filter and the analog reference are not part of this block. It only produces the three control levels for them.

Top module: `en_strap_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `pwr_on_o`, `hperf_o` and `deemph_o` are all 0.
- R2: An enable that is already high when reset is released does not power the block up. Power-up needs enable to be seen low and then high.
- R3: A low-to-high transition on `en_i` sets `pwr_on_o` to 1 on the third control clock edge after the change, provided the master clock is running.
- R4: `hperf_o` takes the value of `mode_pin_i` at the enable rising edge, where 1 means high-performance and 0 means normal. Later changes of `mode_pin_i` do not alter it while enable stays high.
- R5: While powered, `deemph_o` follows `mode_pin_i`, where 1 means de-emphasis on, with a two-edge delay. It is 0 whenever `pwr_on_o` is 0.
- R6: Enable going low clears `pwr_on_o`, `hperf_o` and `deemph_o` on the third control edge after the change.
- R7: When the master clock stops, `pwr_on_o` and `deemph_o` fall once IDLE_LIMIT control cycles have passed with no master activity. They do not fall earlier.
- R8: When the master clock resumes while enable is still high, power returns within a few control cycles with no new enable edge. The latched mode is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow free-running control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mclk_i | input | 1 | Master clock under watch |
| en_i | input | 1 | Asynchronous enable pin |
| mode_pin_i | input | 1 | Shared strap / de-emphasis pin, asynchronous |
| pwr_on_o | output | 1 | Core power-on |
| hperf_o | output | 1 | High-performance mode latched at power-up |
| deemph_o | output | 1 | De-emphasis enable |

## Verification
The bench holds enable high through reset. A design that treats a static high level as a power-up request would power on at that point. Across random trials it toggles the shared pin after power-up and checks that the strap stays frozen while de-emphasis tracks the pin. A design that samples the pin continuously would let high-performance mode drift, and one that latches de-emphasis would stop following the pin. It stops the master clock and checks power both just before and just after the idle limit, which exposes an off-by-many timeout. It then restarts the clock to catch a design that needs a fresh enable edge to recover.

// File: rtl/en_strap_ctrl.sv
module en_strap_ctrl #(
  parameter int IDLE_LIMIT = 49152
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  input  logic en_i,
  input  logic mode_pin_i,
  output logic pwr_on_o,
  output logic hperf_o,
  output logic deemph_o
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_LIMIT);

  logic [2:0]    en_sh;
  logic [1:0]    pin_sh;
  logic          tgl;
  logic [2:0]    mc_sh;
  logic [CW-1:0] idle_cnt;
  logic          on_q, hperf_q;

  wire en_s  = en_sh[1];
  wire en_d  = en_sh[2];
  wire pin_s = pin_sh[1];
  wire rise  = en_s & ~en_d;
  wire act   = mc_sh[2] ^ mc_sh[1];
  wire dead  = (idle_cnt == LIMIT);

  always_ff @(posedge mclk_i or negedge rst_ni)
    if (!rst_ni) tgl <= 1'b0;
    else         tgl <= ~tgl;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_sh  <= 3'b111;
      pin_sh <= 2'b00;
      mc_sh  <= 3'b000;
    end else begin
      en_sh  <= {en_sh[1:0], en_i};
      pin_sh <= {pin_sh[0], mode_pin_i};
      mc_sh  <= {mc_sh[1:0], tgl};
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     idle_cnt <= '0;
    else if (act)    idle_cnt <= '0;
    else if (!dead)  idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      on_q    <= 1'b0;
      hperf_q <= 1'b0;
    end else if (!en_s) begin
      on_q    <= 1'b0;
      hperf_q <= 1'b0;
    end else if (rise) begin
      on_q    <= 1'b1;
      hperf_q <= pin_s;
    end

  assign pwr_on_o = on_q & ~dead;
  assign hperf_o  = hperf_q;
  assign deemph_o = pwr_on_o & pin_s;
endmodule

module en_strap_ctrl_chk #(
  parameter int IDLE_LIMIT = 49152
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s,
  input logic en_d,
  input logic on_q,
  input logic pwr_on_o,
  input logic hperf_o,
  input logic deemph_o
);
  // R3
  rise_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && !en_d) |=> on_q);
  // R6
  low_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> (!pwr_on_o && !hperf_o));
  // R4
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && $past(on_q)) |-> $stable(hperf_o));
  // R5
  deemph_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deemph_o |-> $past(en_s));
  // R2
  pwr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_on_o) |-> $past(en_s));
endmodule

bind en_strap_ctrl en_strap_ctrl_chk #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_s     (en_sh[1]),
  .en_d     (en_sh[2]),
  .on_q     (on_q),
  .pwr_on_o (pwr_on_o),
  .hperf_o  (hperf_o),
  .deemph_o (deemph_o)
);

// File: tb/en_strap_ctrl_bench.sv
`timescale 1ns/1ps
module en_strap_ctrl_bench;
  localparam int LIM = 40;

  logic clk = 1'b0, mclk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, pin = 1'b0, mclk_run = 1'b1;
  logic pwr, hp, de;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  en_strap_ctrl #(.IDLE_LIMIT(LIM)) u_en_strap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk), .en_i(en),
    .mode_pin_i(pin), .pwr_on_o(pwr), .hperf_o(hp), .deemph_o(de));

  always #2 clk = ~clk;
  always begin #6; if (mclk_run) mclk = ~mclk; end

  function automatic logic exp_de(input logic on, input logic p);
    return on & p;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    chk("R1 pwr in reset", pwr, 1'b0);
    chk("R1 hperf in reset", hp, 1'b0);
    chk("R1 deemph in reset", de, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 pwr after reset", pwr, 1'b0);
    cyc(10);
    chk("R2 static high enable", pwr, 1'b0);

    en = 1'b0; cyc(5);
    en = 1'b1; pin = 1'b1;
    cyc(2);
    chk("R3 not before third edge", pwr, 1'b0);
    cyc(1);
    chk("R3 on at third edge", pwr, 1'b1);
    chk("R4 strap high", hp, 1'b1);
    chk("R5 deemph follows", de, 1'b1);
    pin = 1'b0; cyc(3);
    chk("R4 strap frozen", hp, 1'b1);
    chk("R5 deemph off", de, 1'b0);
    en = 1'b0; cyc(3);
    chk("R6 pwr off", pwr, 1'b0);
    chk("R6 hperf cleared", hp, 1'b0);

    for (int t = 0; t < 20; t++) begin
      logic strap;
      strap = 1'($urandom % 2);
      pin = strap; en = 1'b1; cyc(5);
      chk("R3 random power-up", pwr, 1'b1);
      chk("R4 random strap", hp, strap);
      for (int k = 0; k < 4; k++) begin
        logic p;
        p = 1'($urandom % 2);
        pin = p; cyc(3);
        chk("R5 random deemph", de, exp_de(1'b1, p));
        chk("R4 strap held", hp, strap);
      end
      pin = 1'b1; en = 1'b0; cyc(4);
      chk("R6 random off", pwr, 1'b0);
      chk("R5 deemph off when down", de, 1'b0);
    end

    pin = 1'b0; en = 1'b1; cyc(5);
    pin = 1'b1; cyc(3);
    chk("R3 on before stop", pwr, 1'b1);
    mclk_run = 1'b0;
    cyc(LIM - 10);
    chk("R7 still on before limit", pwr, 1'b1);
    cyc(20);
    chk("R7 off after limit", pwr, 1'b0);
    chk("R7 deemph off", de, 1'b0);
    mclk_run = 1'b1;
    cyc(10);
    chk("R8 power returns", pwr, 1'b1);
    chk("R8 mode kept", hp, 1'b0);
    chk("R8 deemph returns", de, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule